// File: doc/BRIEF.md
# Reset-Gated RAM Chip-Enable Controller

This block sits between a processor's active-low RAM chip-enable and the memory. While the system is out of reset, the enable passes through, registered once. When reset arrives, the path closes so that a collapsing supply cannot corrupt memory.

When the path closes, the input is marked high impedance and an active pull-up holds the memory-side enable high. The path stays closed for the whole reset timeout phase and for as long as the system runs from backup power.

A write may be under way when reset arrives, shown by the enable already being low. In that case the block keeps the memory enable low for a bounded grace window of `GRACE_CYCLES` clocks, or until the processor releases the enable, whichever comes first.

The block has three internal phases:
- pass
- grace
- blocked

Every output is registered, so each change shows at the outputs one clock after the inputs that cause it. The block has no streaming data path, so all pins are plain level signals.

Top module: `ce_reset_gate`

## Requirements
- R1: In the pass phase, with `sys_rst`, `rst_hold` and `bkup_mode` all low, `ce_out_n` equals the `ce_in_n` sampled at the previous clock edge, and `ce_in_hiz` and `pullup_en` are 0.
- R2: From the pass phase, if `sys_rst` or `rst_hold` is seen high while `ce_in_n` is high (1), the next cycle shows `ce_out_n`=1, `ce_in_hiz`=1 and `pullup_en`=1.
- R3: From the pass phase, if reset (`sys_rst` or `rst_hold`) is seen high while `ce_in_n` is low (0), `ce_out_n` stays 0 with `ce_in_hiz`=0 and `pullup_en`=0 for exactly `GRACE_CYCLES` cycles when `ce_in_n` stays low. After that the path is blocked.
- R4: During the grace window, `ce_in_n` seen high ends the window, and the next cycle shows the blocked outputs (1,1,1).
- R5: The blocked phase holds, whatever `ce_in_n` does, while `sys_rst` or `rst_hold` is high. It returns to pass on the edge where `sys_rst`, `rst_hold` and `bkup_mode` are all seen low. The first pass-phase output equals `ce_in_n` from that edge.
- R6: `bkup_mode` seen high in any phase, including mid-grace, gives the blocked outputs (1,1,1) on the next cycle.
- R7: A grace window never starts from the blocked phase, even when `ce_in_n` is low and reset is seen again.
- R8: While `rst_n` is low, the outputs are `ce_out_n`=1, `ce_in_hiz`=1 and `pullup_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| sys_rst | input | 1 | High while system reset is asserted |
| rst_hold | input | 1 | High during the reset timeout phase |
| bkup_mode | input | 1 | High while running from backup power |
| ce_out_n | output | 1 | Gated active-low chip-enable to the RAM |
| ce_in_hiz | output | 1 | High when the input side is high impedance |
| pullup_en | output | 1 | High when the output pull-up is active |

## Verification
The bench aims at the cycle where reset meets a low enable. A design that closed the gate at once would drive `ce_out_n` high mid-write. A window off by one would show `GRACE_CYCLES`±1 low cycles in the counted run.

The bench also releases the enable early inside the window and raises backup power mid-window. A design that ignored either would keep `ce_out_n` low too long.

Finally, the bench toggles the enable and re-raises reset while the path is blocked. A design that re-armed the grace window there, or leaked the input through during the timeout phase, would show a low `ce_out_n`.

// File: rtl/ceg_pkg.sv
`timescale 1ns/1ps
package ceg_pkg;
  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_GRACE = 2'd1,
    ST_BLOCK = 2'd2
  } gate_st_t;
endpackage

// File: rtl/ceg_grace_timer.sv
`timescale 1ns/1ps
module ceg_grace_timer #(
  parameter int GRACE_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW   = $clog2(GRACE_CYCLES + 1);
  localparam int LAST = GRACE_CYCLES - 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CW'(LAST));

  // window length never exceeds the parameter
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LAST));
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));
endmodule

// File: rtl/ceg_fsm.sv
`timescale 1ns/1ps
module ceg_fsm
  import ceg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_in_n,
  input  logic     trig,
  input  logic     bkup,
  input  logic     done,
  output gate_st_t st_q,
  output gate_st_t st_d,
  output logic     start,
  output logic     run
);
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_PASS: begin
        if (bkup)      st_d = ST_BLOCK;
        else if (trig) st_d = ce_in_n ? ST_BLOCK : ST_GRACE;
      end
      ST_GRACE: begin
        if (bkup || ce_in_n || done) st_d = ST_BLOCK;
      end
      ST_BLOCK: begin
        if (!bkup && !trig) st_d = ST_PASS;
      end
      default: st_d = ST_BLOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_BLOCK;
    else        st_q <= st_d;
  end

  assign start = (st_q == ST_PASS) && (st_d == ST_GRACE);
  assign run   = (st_q == ST_GRACE);

  assert_early_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRACE && ce_in_n) |=> (st_q == ST_BLOCK));
  assert_hold_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLOCK && trig) |=> (st_q == ST_BLOCK));
  assert_backup_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bkup |=> (st_q == ST_BLOCK));
  assert_no_regrace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLOCK) |=> (st_q != ST_GRACE));
endmodule

// File: rtl/ceg_out_stage.sv
`timescale 1ns/1ps
module ceg_out_stage
  import ceg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gate_st_t st_d,
  input  logic     ce_in_n,
  output logic     ce_out_n,
  output logic     ce_in_hiz,
  output logic     pullup_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_out_n  <= 1'b1;
      ce_in_hiz <= 1'b1;
      pullup_en <= 1'b1;
    end else begin
      case (st_d)
        ST_PASS: begin
          ce_out_n  <= ce_in_n;
          ce_in_hiz <= 1'b0;
          pullup_en <= 1'b0;
        end
        ST_GRACE: begin
          ce_out_n  <= 1'b0;
          ce_in_hiz <= 1'b0;
          pullup_en <= 1'b0;
        end
        default: begin
          ce_out_n  <= 1'b1;
          ce_in_hiz <= 1'b1;
          pullup_en <= 1'b1;
        end
      endcase
    end
  end

  assert_pullup_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en |-> (ce_out_n && ce_in_hiz));
endmodule

// File: rtl/ce_reset_gate.sv
`timescale 1ns/1ps
module ce_reset_gate
  import ceg_pkg::*;
#(
  parameter int GRACE_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic sys_rst,
  input  logic rst_hold,
  input  logic bkup_mode,
  output logic ce_out_n,
  output logic ce_in_hiz,
  output logic pullup_en
);
  gate_st_t st_q, st_d;
  logic     trig, start, run, done;

  assign trig = sys_rst | rst_hold;

  ceg_grace_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .done(done)
  );

  ceg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .trig(trig), .bkup(bkup_mode),
    .done(done), .st_q(st_q), .st_d(st_d), .start(start), .run(run)
  );

  ceg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .st_d(st_d), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .ce_in_hiz(ce_in_hiz), .pullup_en(pullup_en)
  );

  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS && !trig && !bkup_mode) |=>
      (ce_out_n == $past(ce_in_n) && !ce_in_hiz && !pullup_en));
  assert_backup_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_mode |=> (pullup_en && ce_out_n));
endmodule

// File: tb/ce_reset_gate_bench.sv
`timescale 1ns/1ps
module ce_reset_gate_bench;
  localparam int G = 8;

  logic clk = 1'b0, rst_n = 1'b0, ce_in_n = 1'b1;
  logic sys_rst = 1'b0, rst_hold = 1'b0, bkup_mode = 1'b0;
  logic ce_out_n, ce_in_hiz, pullup_en;

  int total = 0, bad = 0;
  string cur_req = "R8";

  ce_reset_gate #(.GRACE_CYCLES(G)) u_ce_reset_gate (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .sys_rst(sys_rst),
    .rst_hold(rst_hold), .bkup_mode(bkup_mode), .ce_out_n(ce_out_n),
    .ce_in_hiz(ce_in_hiz), .pullup_en(pullup_en)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: 0 pass, 1 grace, 2 blocked
  int   m = 2;
  int   g = 0;
  logic e_ce = 1'b1, e_hiz = 1'b1, e_pu = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) m = 2;
    else begin
      if (m == 0) begin
        if (bkup_mode) m = 2;
        else if (sys_rst || rst_hold) begin
          if (!ce_in_n) begin m = 1; g = 1; end
          else m = 2;
        end
      end else if (m == 1) begin
        if (bkup_mode || ce_in_n || g == G) m = 2;
        else g = g + 1;
      end else begin
        if (!bkup_mode && !sys_rst && !rst_hold) m = 0;
      end
    end
    if (m == 0)      begin e_ce = ce_in_n; e_hiz = 0; e_pu = 0; end
    else if (m == 1) begin e_ce = 0;       e_hiz = 0; e_pu = 0; end
    else             begin e_ce = 1;       e_hiz = 1; e_pu = 1; end
  end

  always @(negedge clk) begin
    total++;
    if ({ce_out_n, ce_in_hiz, pullup_en} !== {e_ce, e_hiz, e_pu}) begin
      bad++;
      $display("FAIL %s t=%0t actual ce/hiz/pu=%b%b%b expected=%b%b%b",
               cur_req, $time, ce_out_n, ce_in_hiz, pullup_en, e_ce, e_hiz, e_pu);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lowcnt;
    // R8 reset state
    step(4);
    rst_n = 1'b1;
    step(3);
    // R1 transparent pass
    cur_req = "R1";
    for (int i = 0; i < 20; i++) begin
      ce_in_n = (i % 3 == 0) ? 1'b0 : 1'b1;
      step(1);
    end
    // R2 reset with enable high closes at once
    cur_req = "R2";
    ce_in_n = 1'b1; step(1);
    sys_rst = 1'b1; step(3);
    // R5 timeout phase ignores toggles, then reopens
    cur_req = "R5";
    sys_rst = 1'b0; rst_hold = 1'b1;
    for (int i = 0; i < 6; i++) begin ce_in_n = ~ce_in_n; step(1); end
    ce_in_n = 1'b0; rst_hold = 1'b0; step(4);
    // R3 full grace window, counted directly
    cur_req = "R3";
    ce_in_n = 1'b0; step(1);
    sys_rst = 1'b1;
    lowcnt = 0;
    for (int k = 0; k < G + 3; k++) begin
      step(1);
      if (ce_out_n == 1'b0) lowcnt++;
    end
    total++;
    if (lowcnt != G) begin
      bad++;
      $display("FAIL R3 grace low cycles actual=%0d expected=%0d", lowcnt, G);
    end
    // R7 blocked: low enable plus reset starts no new window
    cur_req = "R7";
    sys_rst = 1'b0; rst_hold = 1'b1; step(2);
    sys_rst = 1'b1; step(3);
    sys_rst = 1'b0; rst_hold = 1'b0; ce_in_n = 1'b1; step(3);
    // R4 early release ends grace
    cur_req = "R4";
    ce_in_n = 1'b0; step(1);
    rst_hold = 1'b1; step(3);
    ce_in_n = 1'b1; step(3);
    rst_hold = 1'b0; step(3);
    // R6 backup from pass, then mid-grace
    cur_req = "R6";
    bkup_mode = 1'b1; step(3);
    bkup_mode = 1'b0; step(2);
    ce_in_n = 1'b0; step(1);
    sys_rst = 1'b1; step(2);
    bkup_mode = 1'b1; step(3);
    sys_rst = 1'b0; step(2);
    bkup_mode = 1'b0; step(3);
    // R1 again after everything
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin ce_in_n = i[0]; step(1); end
    // R8 block reset mid-operation
    cur_req = "R8";
    rst_n = 1'b0; step(3);
    summary();
    $finish;
  end
endmodule